// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the controller-side sequencer that takes an SDRAM device from power-on to a state where normal traffic may begin. From reset it keeps the clock-enable and all data-mask pins high and drives NOP commands for a programmable number of cycles, which covers the device's power-stabilization wait. It then issues a precharge to all banks, a configurable number of auto-refresh commands and a mode register write. A parameter picks whether the refresh group or the mode register write comes second. After the recovery time of the last command has elapsed, `initDone` rises and stays high until the next reset.

The mode register word is built from four small inputs: burst length, burst type, read latency and write-burst mode. Each is placed in a fixed address-pin field. Every reserved address bit and both bank bits are driven low during the write. Each command is followed by NOPs for a parameterized recovery count, so the next command comes exactly that many cycles later. All pin outputs are registered.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and for the first WAIT_CYCLES clock cycles after reset is released, the command pins carry NOP ({csN,rasN,casN,weN} = 0111) with address and bank at zero, and `initDone` is low.
- R2: In the cycle after the wait, the block issues precharge-all ({csN,rasN,casN,weN} = 0010). Address bit 10 is high and all other address bits and bank bits are low.
- R3: Exactly REF_COUNT auto-refresh commands ({csN,rasN,casN,weN} = 0001) are issued. REF_COUNT must be at least 2. Consecutive refreshes are REF_CYCLES cycles apart.
- R4: Exactly one mode register write ({csN,rasN,casN,weN} = 0000) is issued. Its address carries burst length in bits 2:0, burst type in bit 3, read latency in bits 6:4 and write-burst mode in bit 9.
- R5: During the mode register write, address bits 8:7 and 11:10 and both bank bits are low.
- R6: Each command is followed by NOPs, so the next command (or `initDone`) appears exactly PRE_CYCLES after a precharge, REF_CYCLES after a refresh and MRS_CYCLES after a mode write. MRS_CYCLES must be at least 2.
- R7: With MRS_FIRST = 0 the order is precharge, refreshes, mode write. With MRS_FIRST = 1 the order is precharge, mode write, refreshes.
- R8: `initDone` rises exactly one recovery period after the final command. Once high it stays high until reset, and only NOPs follow.
- R9: `sdCke` and every `sdDqm` bit are high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstLen | input | 3 | Burst length code for the mode word |
| burstType | input | 1 | Burst type bit for the mode word |
| casLat | input | 3 | Read latency code for the mode word |
| writeBurstSingle | input | 1 | Write-burst mode bit for the mode word |
| sdCke | output | 1 | Clock enable to the device |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | DQM_W | Data mask lanes |
| sdAddr | output | ADDR_W | Address pins |
| sdBank | output | BANK_W | Bank select pins |
| initDone | output | 1 | Initialization complete, sticky |

## Verification
The assertions assume the parameters are legal: REF_COUNT of two or more, MRS_CYCLES of two or more, every recovery count of at least one, and an address width of at least twelve. Both bench instances respect these limits. The assertions also assume the mode inputs are stable while the mode write is being formed. The bench changes them only while reset is held, so each sequence sees one fixed mode word. It runs three different mode words, each through both ordering variants.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic initOk;
  } seqStrobeT;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } seqStateT;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int WAIT_CYCLES = 25000,
  parameter int PRE_CYCLES  = 3,
  parameter int REF_CYCLES  = 8,
  parameter int MRS_CYCLES  = 2,
  parameter int REF_COUNT   = 2,
  parameter bit MRS_FIRST   = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  output seqStrobeT strobe
);

  localparam int MAX_A   = (WAIT_CYCLES > PRE_CYCLES) ? WAIT_CYCLES : PRE_CYCLES;
  localparam int MAX_B   = (REF_CYCLES > MRS_CYCLES) ? REF_CYCLES : MRS_CYCLES;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int REF_W   = $clog2(REF_COUNT + 1);

  seqStateT         state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stepLen;
  logic [REF_W-1:0] refIdx;
  logic             lastCyc;
  logic             lastRef;

  always_comb begin
    case (state)
      ST_WAIT: stepLen = CNT_W'(WAIT_CYCLES);
      ST_PRE:  stepLen = CNT_W'(PRE_CYCLES);
      ST_REF:  stepLen = CNT_W'(REF_CYCLES);
      ST_MRS:  stepLen = CNT_W'(MRS_CYCLES);
      default: stepLen = CNT_W'(1);
    endcase
  end

  assign lastCyc = (cnt == stepLen - CNT_W'(1));
  assign lastRef = (refIdx == REF_W'(REF_COUNT - 1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_WAIT: stateNext = ST_PRE;
      ST_PRE:  stateNext = MRS_FIRST ? ST_MRS : ST_REF;
      ST_REF:  stateNext = lastRef ? (MRS_FIRST ? ST_DONE : ST_MRS) : ST_REF;
      ST_MRS:  stateNext = MRS_FIRST ? ST_REF : ST_DONE;
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_WAIT;
      cnt    <= '0;
      refIdx <= '0;
    end else if (state != ST_DONE) begin
      if (lastCyc) begin
        state <= stateNext;
        cnt   <= '0;
        if (state == ST_REF) refIdx <= refIdx + REF_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.issuePre = (state == ST_PRE) && (cnt == '0);
    strobe.issueRef = (state == ST_REF) && (cnt == '0);
    strobe.issueMrs = (state == ST_MRS) && (cnt == '0);
    strobe.initOk   = (state == ST_DONE);
  end

  // checker-only tally of refresh strobes
  logic [REF_W:0] refSeen;
  always_ff @(posedge clk) begin
    if (!rstN) refSeen <= '0;
    else if (strobe.issueRef) refSeen <= refSeen + 1'b1;
  end

  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issuePre, strobe.issueRef, strobe.issueMrs}));

  p_mrs_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueMrs |=> !(strobe.issuePre || strobe.issueRef || strobe.issueMrs || strobe.initOk));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initOk |=> strobe.initOk);

  p_ref_total_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initOk |-> (refSeen == (REF_W+1)'(REF_COUNT)));

endmodule

// File: rtl/sdinit_dp.sv
module sdinit_dp
  import sdinit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [2:0]        burstLen,
  input  logic              burstType,
  input  logic [2:0]        casLat,
  input  logic              writeBurstSingle,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [DQM_W-1:0]  sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic              initDone
);

  logic [ADDR_W-1:0] modeWord;
  logic [ADDR_W-1:0] addrNext;
  logic [3:0]        cmdNext;
  logic [3:0]        cmdQ;

  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = burstLen;
    modeWord[3]   = burstType;
    modeWord[6:4] = casLat;
    modeWord[9]   = writeBurstSingle;
  end

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.issuePre) begin
      cmdNext      = CMD_PRE;
      addrNext[10] = 1'b1;
    end else if (strobe.issueRef) begin
      cmdNext = CMD_REF;
    end else if (strobe.issueMrs) begin
      cmdNext  = CMD_MRS;
      addrNext = modeWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_NOP;
      sdAddr   <= '0;
      sdBank   <= '0;
      initDone <= 1'b0;
      sdCke    <= 1'b1;
      sdDqm    <= '1;
    end else begin
      cmdQ     <= cmdNext;
      sdAddr   <= addrNext;
      sdBank   <= '0;
      initDone <= strobe.initOk;
      sdCke    <= 1'b1;
      sdDqm    <= '1;
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;

  p_mrs_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_MRS) |-> (sdAddr[8:7] == 2'b00 && sdAddr[11:10] == 2'b00 && sdBank == '0));

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issuePre |=> (cmdQ == CMD_PRE && sdAddr[10]));

  p_cke_dqm_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    sdCke && (&sdDqm));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cmdQ == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int WAIT_CYCLES = 25000,
  parameter int PRE_CYCLES  = 3,
  parameter int REF_CYCLES  = 8,
  parameter int MRS_CYCLES  = 2,
  parameter int REF_COUNT   = 2,
  parameter bit MRS_FIRST   = 1'b0,
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 2,
  parameter int DQM_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        burstLen,
  input  logic              burstType,
  input  logic [2:0]        casLat,
  input  logic              writeBurstSingle,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [DQM_W-1:0]  sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic              initDone
);

  seqStrobeT strobe;

  sdinit_ctrl #(
    .WAIT_CYCLES(WAIT_CYCLES),
    .PRE_CYCLES (PRE_CYCLES),
    .REF_CYCLES (REF_CYCLES),
    .MRS_CYCLES (MRS_CYCLES),
    .REF_COUNT  (REF_COUNT),
    .MRS_FIRST  (MRS_FIRST)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  sdinit_dp #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .DQM_W (DQM_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .burstLen        (burstLen),
    .burstType       (burstType),
    .casLat          (casLat),
    .writeBurstSingle(writeBurstSingle),
    .sdCke           (sdCke),
    .sdCsN           (sdCsN),
    .sdRasN          (sdRasN),
    .sdCasN          (sdCasN),
    .sdWeN           (sdWeN),
    .sdDqm           (sdDqm),
    .sdAddr          (sdAddr),
    .sdBank          (sdBank),
    .initDone        (initDone)
  );

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int W  = 20;
  localparam int PA = 3, RA = 5, MA = 2, CA = 3;
  localparam int PB = 2, RB = 4, MB = 3, CB = 2;
  localparam int RUN = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] burstLen = '0;
  logic burstType = 1'b0;
  logic [2:0] casLat = '0;
  logic writeBurstSingle = 1'b0;

  always #4 clk = ~clk;

  logic ckeA, csA, rasA, casA, weA, doneA;
  logic [1:0] dqmA, bankA;
  logic [11:0] addrA;
  logic ckeB, csB, rasB, casB, weB, doneB;
  logic [1:0] dqmB, bankB;
  logic [11:0] addrB;

  sdram_init_seq #(.WAIT_CYCLES(W), .PRE_CYCLES(PA), .REF_CYCLES(RA),
    .MRS_CYCLES(MA), .REF_COUNT(CA), .MRS_FIRST(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .burstLen(burstLen), .burstType(burstType),
    .casLat(casLat), .writeBurstSingle(writeBurstSingle),
    .sdCke(ckeA), .sdCsN(csA), .sdRasN(rasA), .sdCasN(casA), .sdWeN(weA),
    .sdDqm(dqmA), .sdAddr(addrA), .sdBank(bankA), .initDone(doneA));

  sdram_init_seq #(.WAIT_CYCLES(W), .PRE_CYCLES(PB), .REF_CYCLES(RB),
    .MRS_CYCLES(MB), .REF_COUNT(CB), .MRS_FIRST(1'b1)) u_dutAlt (
    .clk(clk), .rstN(rstN), .burstLen(burstLen), .burstType(burstType),
    .casLat(casLat), .writeBurstSingle(writeBurstSingle),
    .sdCke(ckeB), .sdCsN(csB), .sdRasN(rasB), .sdCasN(casB), .sdWeN(weB),
    .sdDqm(dqmB), .sdAddr(addrB), .sdBank(bankB), .initDone(doneB));

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model: expected {done, cmd[3:0], addr[11:0], bank[1:0]} at cycle k after release
  function automatic logic [18:0] refModel(input int k, input int pre, input int rf,
      input int mr, input int rc, input bit mrsFirst, input logic [11:0] mode,
      output string tag);
    int kinds[16];
    int n = 0;
    int t = W;
    tag = "R1";
    if (k < t) return {1'b0, 4'b0111, 12'h000, 2'b00};
    kinds[n] = 1; n++;
    if (mrsFirst) begin kinds[n] = 3; n++; end
    for (int i = 0; i < rc; i++) begin kinds[n] = 2; n++; end
    if (!mrsFirst) begin kinds[n] = 3; n++; end
    for (int i = 0; i < n; i++) begin
      int len = (kinds[i] == 1) ? pre : (kinds[i] == 2) ? rf : mr;
      if (k == t) begin
        if (kinds[i] == 1) begin tag = mrsFirst ? "R7/R2" : "R2"; return {1'b0, 4'b0010, 12'h400, 2'b00}; end
        if (kinds[i] == 2) begin tag = mrsFirst ? "R7/R3" : "R3"; return {1'b0, 4'b0001, 12'h000, 2'b00}; end
        tag = mrsFirst ? "R7/R4/R5" : "R4/R5";
        return {1'b0, 4'b0000, mode, 2'b00};
      end
      if (k < t + len) begin tag = "R6"; return {1'b0, 4'b0111, 12'h000, 2'b00}; end
      t += len;
    end
    tag = "R8";
    return {1'b1, 4'b0111, 12'h000, 2'b00};
  endfunction

  task automatic checkOne(input string tag, input logic [18:0] act, input logic [18:0] exp, input int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic checkPins(input int k, input logic [11:0] mode);
    string tagA, tagB;
    logic [18:0] expA, expB;
    expA = refModel(k, PA, RA, MA, CA, 1'b0, mode, tagA);
    expB = refModel(k, PB, RB, MB, CB, 1'b1, mode, tagB);
    checkOne(tagA, {doneA, csA, rasA, casA, weA, addrA, bankA}, expA, k);
    checkOne(tagB, {doneB, csB, rasB, casB, weB, addrB, bankB}, expB, k);
    // R9: clock enable and masks always high
    checkOne("R9", {16'h0, ckeA, dqmA}, {16'h0, 3'b111}, k);
    checkOne("R9", {16'h0, ckeB, dqmB}, {16'h0, 3'b111}, k);
  endtask

  task automatic runPass(input logic [2:0] bl, input logic bt, input logic [2:0] cl, input logic wb);
    logic [11:0] mode;
    @(negedge clk);
    rstN = 1'b0;
    burstLen = bl; burstType = bt; casLat = cl; writeBurstSingle = wb;
    mode = {2'b00, wb, 2'b00, cl, bt, bl};
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOne("R1", {doneA, csA, rasA, casA, weA, addrA, bankA}, {1'b0, 4'b0111, 14'h0}, -1);
    checkOne("R1", {doneB, csB, rasB, casB, weB, addrB, bankB}, {1'b0, 4'b0111, 14'h0}, -1);
    rstN = 1'b1;
    for (int k = 0; k < RUN; k++) begin
      @(posedge clk);
      @(negedge clk);
      checkPins(k, mode);
    end
  endtask

  task automatic finishUp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      finishUp();
    end
  end

  initial begin
    runPass(3'b011, 1'b0, 3'b010, 1'b0);
    runPass(3'b111, 1'b1, 3'b011, 1'b1);
    runPass(3'b000, 1'b1, 3'b101, 1'b0);
    finishUp();
  end

endmodule